// File: doc/BRIEF.md
# Linked-Ring Receive Frame Writer

This block takes received network frames, presented one byte per cycle with start and end markers, and stores them in host memory. Software builds a ring of eight-word descriptors in memory. Each descriptor names a buffer and the next descriptor in the ring. The block walks the ring through a single 32-bit memory master.

For each descriptor, the block reads the leading words. It writes into the buffer only when the descriptor's ownership flag gives it to the block. It then writes back a status word that returns ownership to software. A frame that does not fit in one buffer spills into the following descriptors.

On the closing descriptor of a frame, the block also writes the frame's timestamp and its total length, and it pulses an interrupt. When the next descriptor still belongs to software, the block halts, discards incoming bytes and raises a flag. It stays halted until software pulses a poll strobe.

Top module: `rx_desc_dma`

## Requirements
- R1: A descriptor is eight words at byte offsets 0 to 28. The block reads status (offset 0), control (offset 4), buffer address (offset 8) and next-descriptor address (offset 12). It writes timestamp low at offset 24 and timestamp high at offset 28.
- R2: Frame data goes only into the buffer of a descriptor whose status bit 31 reads 1. Every status write-back carries bit 31 = 0.
- R3: Status bit 9 is set on the descriptor that holds the first segment of a frame. Status bit 8 is set on the descriptor that closes the frame. A middle or first-only segment has bit 8 clear.
- R4: Status bits 29:16 hold the frame's total byte count, CRC bytes included, on the closing descriptor. These bits are 0 on every other status write and when bit 14 is set.
- R5: Control bits 11:2 give the buffer capacity in 32-bit words. Stream byte n of a segment lands in bits 8*(n mod 4)+7 down to 8*(n mod 4) of buffer word n/4. A partial last word is written with byte enables, so untouched bytes keep their old contents.
- R6: The next descriptor is taken from word 3. A frame larger than one buffer continues in the next descriptor, and the following frame starts in the descriptor after the one that closed the previous frame.
- R7: When a buffer is full and the next descriptor is owned by software, the current descriptor is closed with bits 14, 8 and 9 (if first) set and length 0. The rest of that frame is discarded, and the block halts at the next descriptor.
- R8: On a software-owned descriptor, `buf_unavail` is 1, incoming bytes are discarded and no memory writes occur. A `poll_demand` pulse makes the block re-read that same descriptor.
- R9: On the closing descriptor, the timestamp words are written before the status word. The timestamp is `ts_in` sampled when the frame's first word is stored.
- R10: The status word is the last write to a descriptor, and the ownership release happens in that same write.
- R11: `rx_irq` is a one-cycle pulse following acceptance of each closing status write, and only then.
- R12: `mem_req` stays high, with address, direction and write data unchanged, until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| desc_base | input | 32 | Address of the first descriptor, sampled at reset |
| poll_demand | input | 1 | One-cycle strobe to retry a held descriptor |
| ts_in | input | 64 | Current timestamp value |
| rx_valid | input | 1 | Byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_byte | input | 8 | Received byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| rx_irq | output | 1 | Frame-closed pulse |
| buf_unavail | output | 1 | Halted on a software-owned descriptor |

## Verification
The hardest case to reach is the overflow path: a frame must fill one buffer while the descriptor after it is still owned by software. The bench reaches it in two steps. It re-arms only one descriptor with a two-word buffer, leaving its successor released from an earlier frame. It then sends a 20-byte frame. After that, it re-arms the halted descriptor and sends a short frame, to show that the discarded tail never reached memory.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;
  localparam int DATA_W = 32;
  localparam int OWN_BIT = 31;
  localparam int FIRST_BIT = 9;
  localparam int LAST_BIT = 8;
  localparam int TOOBIG_BIT = 14;

  typedef struct packed {
    logic [31:0] data;
    logic [2:0]  nb;
    logic        last;
  } rxdw_word_t;

  typedef enum logic [2:0] {
    ST_FETCH, ST_WAIT, ST_DATA, ST_PEEK, ST_WB, ST_HOLD, ST_DROP
  } rxdw_state_e;

  function automatic logic [31:0] rxdw_status(logic [13:0] len, logic toobig,
                                              logic fs, logic ls);
    return {1'b0, 1'b0, len, 1'b0, toobig, 4'b0000, fs, ls, 8'h00};
  endfunction

  function automatic logic [3:0] rxdw_be(logic [2:0] nb);
    case (nb)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      3'd3:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/rxdw_pack.sv
module rxdw_pack
  import rxdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_byte,
  output logic       out_push,
  output rxdw_word_t out_word
);
  logic [1:0]  lane, l;
  logic [31:0] acc, nacc;

  always_comb begin
    l = in_sof ? 2'd0 : lane;
    nacc = in_sof ? 32'd0 : acc;
    nacc[{l, 3'b000} +: 8] = in_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane <= '0;
      acc <= '0;
      out_push <= 1'b0;
      out_word <= '0;
    end else begin
      out_push <= 1'b0;
      if (in_valid) begin
        if (in_eof || l == 2'd3) begin
          out_push <= 1'b1;
          out_word <= '{data: nacc, nb: 3'(l) + 3'd1, last: in_eof};
          lane <= '0;
          acc <= '0;
        end else begin
          lane <= l + 2'd1;
          acc <= nacc;
        end
      end
    end
  end
endmodule

// File: rtl/rxdw_fifo.sv
module rxdw_fifo
  import rxdw_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  rxdw_word_t din,
  input  logic       pop,
  output rxdw_word_t dout,
  output logic       empty,
  output logic       full
);
  localparam int AW = $clog2(DEPTH);
  rxdw_word_t store [DEPTH];
  logic [AW:0] wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout  = store[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) store[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/rxdw_engine.sv
module rxdw_engine
  import rxdw_pkg::*;
#(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     desc_base,
  input  logic            poll,
  input  logic [TS_W-1:0] ts_in,
  input  logic            fifo_empty,
  input  rxdw_word_t      head,
  output logic            fifo_pop,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  output logic [3:0]      mem_be,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            irq,
  output logic            hold,
  output logic            st_wr
);
  localparam int HALF = TS_W / 2;

  rxdw_state_e     state;
  logic [1:0]      k, wb_idx;
  logic            cont, first, wb_final, wb_de, drop_hold, mid, mid_n;
  logic [31:0]     cur, nxt, bufa;
  logic [9:0]      bwords, wcnt;
  logic [13:0]     flen;
  logic [TS_W-1:0] ts;
  logic            seg_full;
  logic [31:0]     stat;

  assign seg_full = (wcnt == bwords);
  assign hold     = (state == ST_HOLD);
  assign stat     = rxdw_status((wb_final && !wb_de) ? flen : 14'd0, wb_de, first, wb_final);
  assign mid_n    = fifo_empty ? mid : !head.last;

  always_comb begin
    mem_req = 1'b0;
    mem_we = 1'b0;
    mem_addr = cur;
    mem_wdata = '0;
    mem_be = 4'hF;
    fifo_pop = 1'b0;
    st_wr = 1'b0;
    case (state)
      ST_FETCH: begin
        mem_req = 1'b1;
        mem_addr = cur + {28'd0, k, 2'b00};
      end
      ST_PEEK: begin
        mem_req = 1'b1;
        mem_addr = nxt;
      end
      ST_DATA: if (!fifo_empty && !seg_full) begin
        mem_req = 1'b1;
        mem_we = 1'b1;
        mem_addr = bufa + {20'd0, wcnt, 2'b00};
        mem_wdata = head.data;
        mem_be = rxdw_be(head.nb);
        fifo_pop = mem_ack;
      end
      ST_WB: begin
        mem_req = 1'b1;
        mem_we = 1'b1;
        case (wb_idx)
          2'd0: begin mem_addr = cur + 32'd24; mem_wdata = ts[HALF-1:0]; end
          2'd1: begin mem_addr = cur + 32'd28; mem_wdata = ts[TS_W-1:HALF]; end
          default: begin mem_addr = cur; mem_wdata = stat; st_wr = 1'b1; end
        endcase
      end
      ST_HOLD, ST_DROP: fifo_pop = !fifo_empty;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      k <= '0; wb_idx <= '0;
      cont <= 1'b0; first <= 1'b0; wb_final <= 1'b0; wb_de <= 1'b0;
      drop_hold <= 1'b0; mid <= 1'b0;
      cur <= desc_base; nxt <= '0; bufa <= '0;
      bwords <= '0; wcnt <= '0; flen <= '0; ts <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (state)
        ST_FETCH: if (mem_ack) begin
          case (k)
            2'd0: if (!mem_rdata[OWN_BIT]) state <= ST_HOLD; else k <= 2'd1;
            2'd1: begin bwords <= mem_rdata[11:2]; k <= 2'd2; end
            2'd2: begin bufa <= mem_rdata; k <= 2'd3; end
            default: begin
              nxt <= mem_rdata;
              k <= 2'd0;
              wcnt <= '0;
              first <= !cont;
              if (!cont) flen <= '0;
              state <= cont ? ST_DATA : ST_WAIT;
              cont <= 1'b0;
            end
          endcase
        end
        ST_WAIT: if (!fifo_empty) state <= ST_DATA;
        ST_DATA: if (!fifo_empty) begin
          if (seg_full) state <= ST_PEEK;
          else if (mem_ack) begin
            wcnt <= wcnt + 10'd1;
            flen <= flen + {11'd0, head.nb};
            if (first && wcnt == '0) ts <= ts_in;
            if (head.last) begin
              wb_final <= 1'b1; wb_de <= 1'b0; wb_idx <= 2'd0;
              state <= ST_WB;
            end
          end
        end
        ST_PEEK: if (mem_ack) begin
          wb_final <= !mem_rdata[OWN_BIT];
          wb_de <= !mem_rdata[OWN_BIT];
          wb_idx <= mem_rdata[OWN_BIT] ? 2'd2 : 2'd0;
          state <= ST_WB;
        end
        ST_WB: if (mem_ack) begin
          if (wb_idx != 2'd2) wb_idx <= wb_idx + 2'd1;
          else begin
            cur <= nxt;
            irq <= wb_final;
            if (!wb_final) begin
              k <= 2'd1; cont <= 1'b1; state <= ST_FETCH;
            end else if (wb_de) begin
              drop_hold <= 1'b1; state <= ST_DROP;
            end else begin
              k <= 2'd0; cont <= 1'b0; state <= ST_FETCH;
            end
          end
        end
        ST_HOLD: begin
          mid <= mid_n;
          if (poll) begin
            if (mid_n) begin drop_hold <= 1'b0; state <= ST_DROP; end
            else begin k <= 2'd0; cont <= 1'b0; state <= ST_FETCH; end
          end
        end
        ST_DROP: if (!fifo_empty && head.last) begin
          mid <= 1'b0;
          if (drop_hold) state <= ST_HOLD;
          else begin k <= 2'd0; cont <= 1'b0; state <= ST_FETCH; end
        end
        default: state <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rxdw_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     desc_base,
  input  logic            poll_demand,
  input  logic [TS_W-1:0] ts_in,
  input  logic            rx_valid,
  input  logic            rx_sof,
  input  logic            rx_eof,
  input  logic [7:0]      rx_byte,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  output logic [3:0]      mem_be,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic            rx_irq,
  output logic            buf_unavail
);
  logic       word_push, fifo_pop, fifo_empty, fifo_full, st_wr;
  rxdw_word_t word_in, word_head;

  rxdw_pack u_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_sof(rx_sof),
    .in_eof(rx_eof), .in_byte(rx_byte), .out_push(word_push), .out_word(word_in)
  );

  rxdw_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(word_push), .din(word_in), .pop(fifo_pop),
    .dout(word_head), .empty(fifo_empty), .full(fifo_full)
  );

  rxdw_engine #(.TS_W(TS_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .desc_base(desc_base), .poll(poll_demand),
    .ts_in(ts_in), .fifo_empty(fifo_empty), .head(word_head), .fifo_pop(fifo_pop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(rx_irq),
    .hold(buf_unavail), .st_wr(st_wr)
  );
endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [3:0]  mem_be,
  input logic        rx_irq,
  input logic        buf_unavail,
  input logic        st_wr
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
  AST_STATUS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |-> !mem_wdata[31]); // R2
  AST_LEN_ON_CLOSE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr && (!mem_wdata[8] || mem_wdata[14]) |-> mem_wdata[29:16] == 14'd0); // R4
  AST_TOOBIG_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr && mem_wdata[14] |-> mem_wdata[8]); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq); // R11
  AST_IRQ_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(st_wr && mem_ack && mem_wdata[8])); // R11
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unavail |-> !(mem_req && mem_we)); // R8
  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 4'd0); // R5
endmodule

bind rx_desc_dma rx_desc_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .rx_irq(rx_irq),
  .buf_unavail(buf_unavail), .st_wr(st_wr)
);

// File: tb/tb_rx_desc_dma.sv
module tb_rx_desc_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] desc_base = 32'h100;
  logic        poll_demand = 1'b0;
  logic [63:0] ts_in = '0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        mem_req, mem_we, mem_ack, rx_irq, buf_unavail;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        host_we = 1'b0;
  logic [31:0] host_addr = '0, host_data = '0;
  logic [31:0] mem [512];
  int checks = 0, errors = 0;
  int irq_cnt = 0, mon_checks = 0, mon_errs = 0, proto_errs = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0, last_wr = '0, prev_wr = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rx_desc_dma dut (
    .clk(clk), .rst_n(rst_n), .desc_base(desc_base), .poll_demand(poll_demand),
    .ts_in(ts_in), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_byte(rx_byte), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rx_irq(rx_irq), .buf_unavail(buf_unavail)
  );

  // memory model: one-cycle registered acknowledge
  always @(posedge clk) begin
    if (host_we) mem[host_addr[10:2]] <= host_data;
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem[mem_addr[10:2]];
      if (mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end else mem_ack <= 1'b0;
  end

  // port monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend && !(mem_req && mem_addr == pend_addr)) proto_errs++;
      pend <= mem_req && !mem_ack;
      pend_addr <= mem_addr;
      if (mem_req && mem_we && mem_ack) begin
        prev_wr <= last_wr;
        last_wr <= mem_addr;
      end
      if (rx_irq) begin
        irq_cnt++;
        mon_checks++;
        if (last_wr[4:0] != 5'd0 || prev_wr != last_wr + 32'd28) begin
          mon_errs++;
          $display("FAIL R9/R10 write order act last=%h prev=%h exp prev=%h",
                   last_wr, prev_wr, last_wr + 32'd28);
        end
      end
    end
  end

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem[a[10:2]];
  endfunction

  function automatic logic [31:0] stat(int len, bit de, bit fs, bit ls);
    return (32'(len) << 16) | (de ? 32'h4000 : 0) | (fs ? 32'h200 : 0) | (ls ? 32'h100 : 0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic send(int n, logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1);
      rx_byte = seed + 8'(i);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      hwrite(32'h100 + 32'(i) * 32, 32'h8000_0000);
      hwrite(32'h104 + 32'(i) * 32, 32'h0000_4010);
      hwrite(32'h108 + 32'(i) * 32, 32'h400 + 32'(i) * 64);
      hwrite(32'h10C + 32'(i) * 32, 32'h100 + 32'((i + 1) % 3) * 32);
      hwrite(32'h118 + 32'(i) * 32, 32'h0);
      hwrite(32'h11C + 32'(i) * 32, 32'h0);
    end
    hwrite(32'h408, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 1'b1;
    idle(20);
    chk("R11 irq idle after reset", 32'(rx_irq), 0);
    chk("R8 owned first descriptor not held", 32'(buf_unavail), 0);
  endtask

  task automatic t_single;
    ts_in = 64'h1111_2222_3333_4444;
    send(10, 8'h10);
    idle(100);
    chk("R3 R4 R2 closing status", rd(32'h100), stat(10, 0, 1, 1));
    chk("R5 word0 byte order", rd(32'h400), 32'h1312_1110);
    chk("R5 word1", rd(32'h404), 32'h1716_1514);
    chk("R5 partial word byte enables", rd(32'h408), 32'hFFFF_1918);
    chk("R1 R9 timestamp low at 24", rd(32'h118), 32'h3333_4444);
    chk("R1 R9 timestamp high at 28", rd(32'h11C), 32'h1111_2222);
    chk("R11 one irq", 32'(irq_cnt), 1);
  endtask

  task automatic t_span;
    ts_in = 64'h5555_6666_7777_8888;
    send(24, 8'h40);
    idle(150);
    chk("R6 R3 first-only segment", rd(32'h120), stat(0, 0, 1, 0));
    chk("R6 buffer1 last word", rd(32'h44C), 32'h4F4E_4D4C);
    chk("R9 no timestamp on middle", rd(32'h138), 32'h0);
    chk("R6 R4 closing segment", rd(32'h140), stat(24, 0, 0, 1));
    chk("R6 buffer2 word0", rd(32'h480), 32'h5352_5150);
    chk("R9 timestamp high on close", rd(32'h15C), 32'h5555_6666);
    chk("R11 one irq per frame", 32'(irq_cnt), 2);
    chk("R8 halt at released descriptor", 32'(buf_unavail), 1);
  endtask

  task automatic t_hold;
    send(8, 8'h70);
    idle(60);
    chk("R8 buffer untouched while held", rd(32'h400), 32'h1312_1110);
    chk("R8 status untouched while held", rd(32'h100), stat(10, 0, 1, 1));
    chk("R8 no irq while held", 32'(irq_cnt), 2);
    hwrite(32'h100, 32'h8000_0000);
    hwrite(32'h120, 32'h8000_0000);
    hwrite(32'h124, 32'h0000_4008);
    @(negedge clk); poll_demand = 1'b1;
    @(negedge clk); poll_demand = 1'b0;
    idle(20);
    chk("R8 poll resumes", 32'(buf_unavail), 0);
    send(4, 8'h90);
    idle(80);
    chk("R8 refetched descriptor used", rd(32'h100), stat(4, 0, 1, 1));
    chk("R8 data after poll", rd(32'h400), 32'h9392_9190);
    chk("R11 irq count after poll", 32'(irq_cnt), 3);
  endtask

  task automatic t_toobig;
    ts_in = 64'h9999_AAAA_BBBB_CCCC;
    send(20, 8'hA0);
    idle(120);
    chk("R7 too-large close", rd(32'h120), stat(0, 1, 1, 1));
    chk("R7 first word stored", rd(32'h440), 32'hA3A2_A1A0);
    chk("R7 R5 capacity respected", rd(32'h448), 32'h4B4A_4948);
    chk("R9 timestamp on too-large close", rd(32'h138), 32'hBBBB_CCCC);
    chk("R7 irq on too-large close", 32'(irq_cnt), 4);
    chk("R7 halted after overflow", 32'(buf_unavail), 1);
    hwrite(32'h140, 32'h8000_0000);
    @(negedge clk); poll_demand = 1'b1;
    @(negedge clk); poll_demand = 1'b0;
    idle(20);
    send(6, 8'hC0);
    idle(80);
    chk("R7 tail discarded, next frame clean", rd(32'h140), stat(6, 0, 1, 1));
    chk("R7 buffer2 word0", rd(32'h480), 32'hC3C2_C1C0);
    chk("R5 buffer2 partial word", rd(32'h484), 32'h5756_C5C4);
  endtask

  initial begin
    t_reset();
    t_single();
    t_span();
    t_hold();
    t_toobig();
    chk("R12 request held until ack", 32'(proto_errs), 0);
    chk("R10 status last per close", 32'(mon_errs), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errs + 1);
      $finish;
    end
  end
endmodule